// File: doc/BRIEF.md
# Egress Leaky-Bucket Traffic Shaper

This block shapes the output of a single priority queue on a transmit port. It sits between the queue's "has data" flag and the transmit MAC. It grants permission to start frames through `tx_permit`. When the MAC reports that a frame has finished, the shaper inserts an idle gap whose length is proportional to the frame it just sent. As a result the long-term throughput of the queue stays at the programmed rate, and frames go out evenly spaced instead of in bursts. Frames are never dropped; only the spacing between them grows.

Rates are expressed in units of a fixed step. `LINE_RATE` is the number of steps that equals the full line rate. The MAC moves one byte every `CYC_PER_BYTE` clock cycles. The byte count used for accounting can optionally include the preamble, the minimum inter-frame gap, or both, in addition to the destination-address-to-FCS length. A rate of zero, or a rate at or above the line rate, turns shaping off. The stretched gap is computed by a serial divider while the gap is already running, so the arithmetic does not occupy a wide combinational path.

Top module: `shp_egress_shaper`

## Requirements
- R1: While `rst` is high, and after it is released until the first stimulus, `tx_permit` and `gap_active` are low.
- R2: The accounted size of a frame is A = `frm_len` + 8 (when `cfg_add_pre` is 1) + 12 (when `cfg_add_ifg` is 1). The mode inputs are sampled in the cycle in which `frm_end` is high.
- R3: For a shaping rate r with 0 < r < `LINE_RATE`, the stretched gap is G = floor(A·`CYC_PER_BYTE`·`LINE_RATE` / r) − A·`CYC_PER_BYTE`. This value is never negative. r is sampled with `frm_end`.
- R4: After a `frm_end` pulse that is accepted while shaping is enabled, `gap_active` rises in the following cycle. It then stays high for exactly max(G, L) consecutive cycles. L = DW + 1, where DW = clog2(((2^`LEN_W`) − 1 + 20)·`CYC_PER_BYTE`·`LINE_RATE` + 1) is the dividend width.
- R5: `tx_permit` is never high in a cycle in which `gap_active` is high.
- R6: `tx_permit` is registered. In the cycle after a clock edge it equals `q_nonempty` sampled at that edge, ANDed with the absence of a gap in that cycle.
- R7: When `cfg_rate` is 0, or when it is greater than or equal to `LINE_RATE`, a `frm_end` pulse produces no gap. `tx_permit` then tracks `q_nonempty` with one cycle of delay.
- R8: A `frm_end` pulse that arrives while a gap is already active is ignored. The running gap keeps its original length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| q_nonempty | input | 1 | Queue holds at least one frame |
| frm_end | input | 1 | One-cycle pulse from the MAC when a frame finishes |
| frm_len | input | LEN_W | Destination-address-to-FCS byte count of the finished frame |
| cfg_rate | input | RATE_W | Programmed rate in rate steps; 0 disables shaping |
| cfg_add_pre | input | 1 | Include 8 preamble bytes in the accounted size |
| cfg_add_ifg | input | 1 | Include 12 minimum-gap bytes in the accounted size |
| tx_permit | output | 1 | Queue may start a frame |
| gap_active | output | 1 | Stretched idle gap in progress |

## Verification
Both outputs are registered. A level driven on `q_nonempty` therefore appears on `tx_permit` one cycle later. A `frm_end` pulse raises `gap_active` in the cycle after the edge that samples it. The bench drives every input at the falling clock edge and samples outputs at the next falling edge, so each result is read in the first cycle it is due. For the gap, the bench counts the falling edges at which `gap_active` is high. It compares that count with max(G, L), computed arithmetically from the mode, length and rate. At every one of those edges it also confirms that `tx_permit` is low, and at the first edge after the gap it confirms that `tx_permit` is high again.

// File: rtl/shp_pkg.sv
package shp_pkg;
  localparam int PRE_BYTES = 8;
  localparam int IFG_BYTES = 12;
  localparam int EXTRA_MAX = PRE_BYTES + IFG_BYTES;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIV  = 2'd1,
    ST_WAIT = 2'd2
  } shp_state_t;
endpackage

// File: rtl/shp_acct.sv
module shp_acct import shp_pkg::*; #(
  parameter int LEN_W = 11,
  parameter int ACC_W = LEN_W + 1
) (
  input  logic [LEN_W-1:0] len,
  input  logic             add_pre,
  input  logic             add_ifg,
  output logic [ACC_W-1:0] acct
);
  logic [ACC_W-1:0] pre_part, ifg_part;

  always_comb begin
    pre_part = add_pre ? ACC_W'(PRE_BYTES) : '0;
    ifg_part = add_ifg ? ACC_W'(IFG_BYTES) : '0;
    acct     = ACC_W'(len) + pre_part + ifg_part;
  end
endmodule

// File: rtl/shp_div.sv
module shp_div #(
  parameter int DVD_W = 24,
  parameter int DSR_W = 11,
  localparam int CNT_W = $clog2(DVD_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [DVD_W-1:0] dividend,
  input  logic [DSR_W-1:0] divisor,
  output logic             done,
  output logic [DVD_W-1:0] quot
);
  logic [DVD_W-1:0] work;
  logic [DSR_W-1:0] rem, dsr;
  logic [CNT_W-1:0] cnt;
  logic             busy;
  logic [DSR_W:0]   rem_sh;
  logic             ge;
  logic [DSR_W-1:0] rem_nx;

  // one restoring step per cycle: shift in next dividend bit, trial subtract
  always_comb begin
    rem_sh = {rem, work[DVD_W-1]};
    ge     = rem_sh >= {1'b0, dsr};
    rem_nx = ge ? DSR_W'(rem_sh - {1'b0, dsr}) : rem_sh[DSR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
      rem  <= '0;
      dsr  <= '0;
      work <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        work <= dividend;
        dsr  <= divisor;
        rem  <= '0;
        cnt  <= CNT_W'(DVD_W);
        busy <= 1'b1;
      end else if (busy) begin
        rem  <= rem_nx;
        work <= {work[DVD_W-2:0], ge};
        cnt  <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quot = work;
endmodule

// File: rtl/shp_egress_shaper.sv
module shp_egress_shaper import shp_pkg::*; #(
  parameter int LEN_W        = 11,
  parameter int RATE_W       = 11,
  parameter int LINE_RATE    = 1375,
  parameter int CYC_PER_BYTE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              q_nonempty,
  input  logic              frm_end,
  input  logic [LEN_W-1:0]  frm_len,
  input  logic [RATE_W-1:0] cfg_rate,
  input  logic              cfg_add_pre,
  input  logic              cfg_add_ifg,
  output logic              tx_permit,
  output logic              gap_active
);
  localparam int ACC_W   = LEN_W + 1;
  localparam int MAX_DVD = ((2**LEN_W) - 1 + EXTRA_MAX) * CYC_PER_BYTE * LINE_RATE;
  localparam int DVD_W   = $clog2(MAX_DVD + 1);
  localparam int LAT     = DVD_W + 1;
  localparam int SCALE   = CYC_PER_BYTE * LINE_RATE;

  logic [ACC_W-1:0] acct;
  logic             shaping, accept, div_done, gap_n;
  logic [DVD_W-1:0] dividend, quot, prod_q, diff, wait_cnt;
  shp_state_t       state;

  shp_acct #(.LEN_W(LEN_W), .ACC_W(ACC_W)) u_acct (
    .len(frm_len), .add_pre(cfg_add_pre), .add_ifg(cfg_add_ifg), .acct(acct)
  );

  assign shaping  = (cfg_rate != '0) && ({1'b0, cfg_rate} < (RATE_W+1)'(LINE_RATE));
  assign accept   = frm_end && shaping && (state == ST_IDLE);
  assign dividend = DVD_W'(acct) * DVD_W'(SCALE);
  assign diff     = quot - prod_q;

  shp_div #(.DVD_W(DVD_W), .DSR_W(RATE_W)) u_div (
    .clk(clk), .rst(rst), .start(accept), .dividend(dividend),
    .divisor(cfg_rate), .done(div_done), .quot(quot)
  );

  // gap level for the next cycle
  always_comb begin
    unique case (state)
      ST_IDLE: gap_n = accept;
      ST_DIV:  gap_n = !(div_done && (diff <= DVD_W'(LAT)));
      ST_WAIT: gap_n = (wait_cnt != DVD_W'(1));
      default: gap_n = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      prod_q     <= '0;
      wait_cnt   <= '0;
      gap_active <= 1'b0;
      tx_permit  <= 1'b0;
    end else begin
      gap_active <= gap_n;
      tx_permit  <= q_nonempty && !gap_n;
      unique case (state)
        ST_IDLE: if (accept) begin
          prod_q <= DVD_W'(acct) * DVD_W'(CYC_PER_BYTE);
          state  <= ST_DIV;
        end
        ST_DIV: if (div_done) begin
          if (diff > DVD_W'(LAT)) begin
            wait_cnt <= diff - DVD_W'(LAT);
            state    <= ST_WAIT;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_WAIT: begin
          wait_cnt <= wait_cnt - 1'b1;
          if (wait_cnt == DVD_W'(1)) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/shp_egress_chk.sv
module shp_egress_chk #(
  parameter int RATE_W    = 11,
  parameter int LINE_RATE = 1375
) (
  input logic              clk,
  input logic              rst,
  input logic              q_nonempty,
  input logic              frm_end,
  input logic [RATE_W-1:0] cfg_rate,
  input logic              tx_permit,
  input logic              gap_active
);
  logic shaping_cfg;
  assign shaping_cfg = (cfg_rate != '0) && ({1'b0, cfg_rate} < (RATE_W+1)'(LINE_RATE));

  // R5
  permit_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(tx_permit && gap_active));

  // R6
  permit_src_chk: assert property (@(posedge clk) disable iff (rst)
    tx_permit |-> $past(q_nonempty));

  // R4
  gap_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(gap_active) |-> $past(frm_end));

  // R4
  gap_start_chk: assert property (@(posedge clk) disable iff (rst)
    (frm_end && shaping_cfg && !gap_active) |=> gap_active);

  // R7
  bypass_chk: assert property (@(posedge clk) disable iff (rst)
    (frm_end && !shaping_cfg && !gap_active) |=> !gap_active);
endmodule

bind shp_egress_shaper shp_egress_chk #(.RATE_W(RATE_W), .LINE_RATE(LINE_RATE)) u_chk (
  .clk(clk), .rst(rst), .q_nonempty(q_nonempty), .frm_end(frm_end),
  .cfg_rate(cfg_rate), .tx_permit(tx_permit), .gap_active(gap_active)
);

// File: tb/sim_shp_egress_shaper.sv
module sim_shp_egress_shaper;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 6, RATE_W = 5, LINE = 16, CPB = 2;
  localparam int DW = $clog2(((2**LEN_W) - 1 + 20) * CPB * LINE + 1);
  localparam int LAT = DW + 1;

  logic clk = 1'b0, rst = 1'b1;
  logic q_nonempty = 1'b0, frm_end = 1'b0, pre = 1'b0, ifg = 1'b0;
  logic [LEN_W-1:0] len = '0;
  logic [RATE_W-1:0] rate = '0;
  logic tx_permit, gap_active;
  int checks = 0, fails = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shp_egress_shaper #(.LEN_W(LEN_W), .RATE_W(RATE_W), .LINE_RATE(LINE), .CYC_PER_BYTE(CPB)) u0 (
    .clk(clk), .rst(rst), .q_nonempty(q_nonempty), .frm_end(frm_end), .frm_len(len),
    .cfg_rate(rate), .cfg_add_pre(pre), .cfg_add_ifg(ifg),
    .tx_permit(tx_permit), .gap_active(gap_active));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (len=%0d rate=%0d pre=%0d ifg=%0d)",
               req, act, exp, len, rate, pre, ifg);
    end
  endtask

  function automatic int exp_gap(input int l, input int r, input bit p, input bit g);
    int a, gg;
    a = l + (p ? 8 : 0) + (g ? 12 : 0);            // R2
    if (r == 0 || r >= LINE) return 0;             // R7
    gg = (a * CPB * LINE) / r - a * CPB;           // R3
    return (gg > LAT) ? gg : LAT;                  // R4
  endfunction

  // R4 R5 R8: drive one frame end, count gap cycles; optionally inject a second pulse mid-gap
  task automatic run(input int l, input int r, input bit p, input bit g, input bit poke);
    int n, e;
    e = exp_gap(l, r, p, g);
    len = LEN_W'(l); rate = RATE_W'(r); pre = p; ifg = g; frm_end = 1'b1;
    @(negedge clk);
    frm_end = 1'b0;
    n = 0;
    while (gap_active && n < 5000) begin
      chk("R5 permit during gap", int'(tx_permit), 0);
      frm_end = poke && (n == 3);
      if (poke && n == 3) len = LEN_W'(63);
      n++;
      @(negedge clk);
    end
    frm_end = 1'b0;
    chk(poke ? "R8 gap length with ignored pulse" : "R4 gap length", n, e);
    chk("R6 permit after gap", int'(tx_permit), 1);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected=<190000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 permit in reset", int'(tx_permit), 0);
    chk("R1 gap in reset", int'(gap_active), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 permit after reset", int'(tx_permit), 0);
    chk("R1 gap after reset", int'(gap_active), 0);

    // R6 R7 bypass: permit follows queue with one cycle delay
    rate = '0;
    q_nonempty = 1'b1;
    chk("R6 permit before register", int'(tx_permit), 0);
    @(negedge clk);
    chk("R7 permit follows queue", int'(tx_permit), 1);
    q_nonempty = 1'b0;
    @(negedge clk);
    chk("R7 permit drops with queue", int'(tx_permit), 0);
    q_nonempty = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R7 sweep over modes, lengths and all rates
    for (int m = 0; m < 4; m++) begin
      for (int li = 0; li < 3; li++) begin
        for (int r = 0; r < 32; r++) begin
          run((li == 0) ? 0 : (li == 1) ? 7 : 63, r, m[0], m[1], 1'b0);
        end
      end
    end

    // R8 pulses during an active gap
    run(40, 1, 1'b0, 1'b0, 1'b1);
    run(20, 3, 1'b1, 1'b1, 1'b1);

    // R6 gap ends while queue empty: permit stays low
    q_nonempty = 1'b0;
    len = LEN_W'(5); rate = RATE_W'(8); pre = 1'b0; ifg = 1'b0; frm_end = 1'b1;
    @(negedge clk);
    frm_end = 1'b0;
    repeat (LAT + 4) @(negedge clk);
    chk("R6 permit with empty queue", int'(tx_permit), 0);
    chk("R4 gap finished", int'(gap_active), 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule